// File: doc/BRIEF.md
# Wired-Line System Test Initiator

This block starts a system test on a shared, active-low control line. Every node on the line can pull the line low. On a start request the block latches a 5-bit test code and its own two result bits. It then drives the test in order: a start sequence, three indicator periods and five parameter bits. Next it keeps the line released through a test pause and a startup interval. Last it walks the result sequence, in which every node class owns two slots: first an "alive" slot, then a "result" slot. The stable-lock test uses code 00100b, but any 5-bit code can be issued.

The result sequence always runs through the slots of every possible node class, up to the parameter `MC`, even for classes that are not fitted in the system. The initiator is itself node class 1. In that class's two slots it pulls the line low to report its own alive and result bits. In every slot, its own included, it samples the line at the slot midpoint and collects the outcome into two `MC`-bit vectors. All timing is counted in ticks of an external timebase strobe, so the same logic covers second-scale intervals or short intervals. The block raises a one-clock done flag when the last slot ends.

Top module: `wlt_test_init`

## Requirements
- R1: While reset is asserted and after it is released with no test started, `line_pull` and `test_done` are 0 and both vectors are all zeros. An asynchronous reset during a test releases the line at once and clears the vectors.
- R2: A `start_req` seen while idle latches `test_code`, `own_alive` and `own_lock` and clears both vectors at that clock edge. The line is then pulled low for `T_SYNC` ticks and released for `T_GAP` ticks.
- R3: Next come `N_MARK` indicator periods of `T_MARK` ticks each. In each period the line is pulled low for the first `T_MARK/2` ticks and released for the rest.
- R4: Five parameter slots of `T_PBIT` ticks follow. They carry `test_code[4]` first and `test_code[0]` last. A code bit of 0 pulls the line low for the whole slot, and a bit of 1 leaves it released.
- R5: After the parameters the line stays released for `T_PAUSE` ticks and then for `T_WAKE` ticks.
- R6: The result sequence has `2*MC` slots of `T_SLOT` ticks each, in the order alive(class 1), result(class 1), alive(class 2), result(class 2) and so on. All `MC` classes are always stepped through.
- R7: In slot 0 the block pulls the line low for the whole slot when the latched `own_alive` is 1, and in slot 1 when the latched `own_lock` is 1. It leaves the line released in every other slot. Changes to the own inputs after the start have no effect.
- R8: Each slot is sampled once, on the tick at which `T_SLOT/2` ticks of the slot have already passed. The line passes through a two-flop synchronizer first. A low line stores 1: alive slots go to `alive_vec[n-1]` and result slots go to `lock_vec[n-1]` for class n.
- R9: `test_done` is 1 for exactly one clock, right after the tick that ends the last slot. The block is then idle with the line released, and the vectors hold until the next start.
- R10: A `start_req` while a test is running is ignored: the code, the own bits and the line waveform are unchanged.
- R11: Timing advances only on clocks with `tick` high. Without ticks, the line output, the vectors and the done flag do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_req | input | 1 | Request to start a test (taken only when idle) |
| test_code | input | 5 | Test code sent as the parameter bits, MSB first |
| own_alive | input | 1 | Own alive bit for the class-1 alive slot (1 = alive) |
| own_lock | input | 1 | Own result bit for the class-1 result slot (1 = lock seen) |
| tick | input | 1 | Timebase strobe, one clock wide |
| line_in | input | 1 | Level of the shared line (1 = released) |
| line_pull | output | 1 | Pull-down enable for the shared line |
| test_done | output | 1 | One-clock pulse at the end of the last result slot |
| alive_vec | output | MC | Collected alive bits, bit n-1 for class n |
| lock_vec | output | MC | Collected result bits, bit n-1 for class n |

## Verification
Some rules are checked by the assertions on every cycle:
- nothing moves without a tick;
- a start while busy is ignored;
- an accepted start clears the vectors;
- done lasts one clock and only in idle;
- the line stays released through the pause;
- at most one collected bit changes per clock.

Other behaviour only the bench scenarios can show: the tick-accurate line waveform of each phase, the MSB-first parameter order, walking all `MC` classes, and which slot lands in which vector bit. The bench compares the line on every clock against a tick-count model. It does this under several codes and responder patterns, with a slowed timebase, and with a start request in the middle of a test.

// File: rtl/wlt_pkg.sv
package wlt_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SYNC  = 3'd1,
    PH_GAP   = 3'd2,
    PH_MARK  = 3'd3,
    PH_PARM  = 3'd4,
    PH_PAUSE = 3'd5,
    PH_WAKE  = 3'd6,
    PH_SLOT  = 3'd7
  } phase_t;

  localparam int unsigned NPARM = 5;

  function automatic int unsigned imax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/wlt_seq.sv
module wlt_seq
  import wlt_pkg::*;
#(
  parameter int unsigned MC      = 4,
  parameter int unsigned T_SYNC  = 6,
  parameter int unsigned T_GAP   = 3,
  parameter int unsigned T_MARK  = 4,
  parameter int unsigned N_MARK  = 3,
  parameter int unsigned T_PBIT  = 4,
  parameter int unsigned T_PAUSE = 10,
  parameter int unsigned T_WAKE  = 5,
  parameter int unsigned T_SLOT  = 6,
  parameter int unsigned CW      = 4,
  parameter int unsigned IW      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             tick,
  input  logic [NPARM-1:0] code_in,
  input  logic             own_alive_in,
  input  logic             own_lock_in,
  output phase_t           phase_o,
  output logic [CW-1:0]    cnt_o,
  output logic [IW-1:0]    idx_o,
  output logic [NPARM-1:0] code_o,
  output logic             own_alive_o,
  output logic             own_lock_o,
  output logic             accept_o,
  output logic             smp_o,
  output logic             done_o
);

  localparam logic [CW-1:0] HALF_SLOT = CW'(T_SLOT / 2);

  phase_t           phase_q, phase_d;
  logic [CW-1:0]    cnt_q, cnt_d, end_cnt;
  logic [IW-1:0]    idx_q, idx_d, end_idx;
  logic [NPARM-1:0] code_q;
  logic             oa_q, ol_q;
  logic             done_q, done_d;
  logic             accept;

  // per-phase interval length and repeat count
  always_comb begin
    end_cnt = '0;
    end_idx = '0;
    case (phase_q)
      PH_SYNC:  end_cnt = CW'(T_SYNC - 1);
      PH_GAP:   end_cnt = CW'(T_GAP - 1);
      PH_MARK:  begin end_cnt = CW'(T_MARK - 1); end_idx = IW'(N_MARK - 1); end
      PH_PARM:  begin end_cnt = CW'(T_PBIT - 1); end_idx = IW'(NPARM - 1);  end
      PH_PAUSE: end_cnt = CW'(T_PAUSE - 1);
      PH_WAKE:  end_cnt = CW'(T_WAKE - 1);
      PH_SLOT:  begin end_cnt = CW'(T_SLOT - 1); end_idx = IW'(2 * MC - 1); end
      default:  ;
    endcase
  end

  // next-state logic
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    done_d  = 1'b0;
    accept  = 1'b0;
    if (phase_q == PH_IDLE) begin
      if (start_req) begin
        accept  = 1'b1;
        phase_d = PH_SYNC;
        cnt_d   = '0;
        idx_d   = '0;
      end
    end else if (tick) begin
      if (cnt_q == end_cnt) begin
        cnt_d = '0;
        if (idx_q == end_idx) begin
          idx_d = '0;
          case (phase_q)
            PH_SYNC:  phase_d = PH_GAP;
            PH_GAP:   phase_d = PH_MARK;
            PH_MARK:  phase_d = PH_PARM;
            PH_PARM:  phase_d = PH_PAUSE;
            PH_PAUSE: phase_d = PH_WAKE;
            PH_WAKE:  phase_d = PH_SLOT;
            default:  begin phase_d = PH_IDLE; done_d = 1'b1; end
          endcase
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
    end
  end

  // test parameters, loaded only on an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      oa_q   <= 1'b0;
      ol_q   <= 1'b0;
    end else if (accept) begin
      code_q <= code_in;
      oa_q   <= own_alive_in;
      ol_q   <= own_lock_in;
    end
  end

  assign phase_o     = phase_q;
  assign cnt_o       = cnt_q;
  assign idx_o       = idx_q;
  assign code_o      = code_q;
  assign own_alive_o = oa_q;
  assign own_lock_o  = ol_q;
  assign accept_o    = accept;
  assign smp_o       = (phase_q == PH_SLOT) && tick && (cnt_q == HALF_SLOT);
  assign done_o      = done_q;

endmodule

// File: rtl/wlt_drive.sv
module wlt_drive
  import wlt_pkg::*;
#(
  parameter int unsigned T_MARK = 4,
  parameter int unsigned CW     = 4,
  parameter int unsigned IW     = 3
) (
  input  phase_t           phase,
  input  logic [CW-1:0]    cnt,
  input  logic [IW-1:0]    idx,
  input  logic [NPARM-1:0] code,
  input  logic             own_alive,
  input  logic             own_lock,
  output logic             pull
);

  localparam logic [CW-1:0] MARK_LO = CW'(T_MARK / 2);

  logic cur_bit;

  // parameter bits leave MSB first
  always_comb begin
    cur_bit = 1'b1;
    for (int k = 0; k < int'(NPARM); k++) begin
      if (idx == IW'(k)) cur_bit = code[NPARM-1-k];
    end
  end

  always_comb begin
    pull = 1'b0;
    case (phase)
      PH_SYNC: pull = 1'b1;
      PH_MARK: pull = (cnt < MARK_LO);
      PH_PARM: pull = ~cur_bit;
      PH_SLOT: begin
        if (idx == IW'(0))      pull = own_alive;
        else if (idx == IW'(1)) pull = own_lock;
      end
      default: pull = 1'b0;
    endcase
  end

endmodule

// File: rtl/wlt_collect.sv
module wlt_collect #(
  parameter int unsigned MC = 4,
  parameter int unsigned IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          smp,
  input  logic [IW-1:0] idx,
  input  logic          line_in,
  output logic [MC-1:0] alive_o,
  output logic [MC-1:0] lock_o
);

  logic line_s1, line_s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_s1 <= 1'b1;
      line_s2 <= 1'b1;
    end else begin
      line_s1 <= line_in;
      line_s2 <= line_s1;
    end
  end

  for (genvar c = 0; c < int'(MC); c++) begin : g_cls
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        alive_o[c] <= 1'b0;
        lock_o[c]  <= 1'b0;
      end else if (clr) begin
        alive_o[c] <= 1'b0;
        lock_o[c]  <= 1'b0;
      end else if (smp) begin
        if (idx == IW'(2 * c))     alive_o[c] <= ~line_s2;
        if (idx == IW'(2 * c + 1)) lock_o[c]  <= ~line_s2;
      end
    end
  end

endmodule

// File: rtl/wlt_test_init.sv
module wlt_test_init
  import wlt_pkg::*;
#(
  parameter int unsigned MC      = 4,
  parameter int unsigned T_SYNC  = 6,
  parameter int unsigned T_GAP   = 3,
  parameter int unsigned T_MARK  = 4,
  parameter int unsigned N_MARK  = 3,
  parameter int unsigned T_PBIT  = 4,
  parameter int unsigned T_PAUSE = 10,
  parameter int unsigned T_WAKE  = 5,
  parameter int unsigned T_SLOT  = 6
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          start_req,
  input  logic [4:0]    test_code,
  input  logic          own_alive,
  input  logic          own_lock,
  input  logic          tick,
  input  logic          line_in,
  output logic          line_pull,
  output logic          test_done,
  output logic [MC-1:0] alive_vec,
  output logic [MC-1:0] lock_vec
);

  localparam int unsigned LMAX = imax(imax(imax(T_SYNC, T_GAP), imax(T_MARK, T_PBIT)),
                                      imax(imax(T_PAUSE, T_WAKE), T_SLOT));
  localparam int unsigned CW   = imax($clog2(LMAX + 1), 1);
  localparam int unsigned IW   = imax($clog2(imax(imax(2 * MC, N_MARK), NPARM)), 1);

  logic rst_m, rst_n;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rst_m <= 1'b0;
      rst_n <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_n <= rst_m;
    end
  end

  phase_t           phase;
  logic [CW-1:0]    cnt;
  logic [IW-1:0]    idx;
  logic [NPARM-1:0] code_l;
  logic             oa_l, ol_l, accept, smp;

  wlt_seq #(
    .MC(MC), .T_SYNC(T_SYNC), .T_GAP(T_GAP), .T_MARK(T_MARK), .N_MARK(N_MARK),
    .T_PBIT(T_PBIT), .T_PAUSE(T_PAUSE), .T_WAKE(T_WAKE), .T_SLOT(T_SLOT),
    .CW(CW), .IW(IW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .tick(tick),
    .code_in(test_code), .own_alive_in(own_alive), .own_lock_in(own_lock),
    .phase_o(phase), .cnt_o(cnt), .idx_o(idx), .code_o(code_l),
    .own_alive_o(oa_l), .own_lock_o(ol_l), .accept_o(accept),
    .smp_o(smp), .done_o(test_done)
  );

  wlt_drive #(.T_MARK(T_MARK), .CW(CW), .IW(IW)) u_drive (
    .phase(phase), .cnt(cnt), .idx(idx), .code(code_l),
    .own_alive(oa_l), .own_lock(ol_l), .pull(line_pull)
  );

  wlt_collect #(.MC(MC), .IW(IW)) u_collect (
    .clk(clk), .rst_n(rst_n), .clr(accept), .smp(smp), .idx(idx),
    .line_in(line_in), .alive_o(alive_vec), .lock_o(lock_vec)
  );

endmodule

// File: rtl/wlt_chk.sv
module wlt_chk
  import wlt_pkg::*;
#(
  parameter int unsigned MC = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_req,
  input logic          tick,
  input phase_t        phase,
  input logic          line_pull,
  input logic          test_done,
  input logic [MC-1:0] alive_vec,
  input logic [MC-1:0] lock_vec
);

  p_clear_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && start_req) |=>
      (alive_vec == '0 && lock_vec == '0 && line_pull && phase == PH_SYNC));

  p_pause_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PAUSE || phase == PH_WAKE) |-> !line_pull);

  p_one_bit_per_clock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SLOT) |=>
      ($countones((alive_vec ^ $past(alive_vec)) | (lock_vec ^ $past(lock_vec))) <= 1));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    test_done |=> !test_done);

  p_done_in_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    test_done |-> (phase == PH_IDLE && !line_pull));

  p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && start_req && !tick) |=> ($stable(phase) && $stable(line_pull)));

  p_no_tick_no_motion_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !start_req) |=>
      ($stable(line_pull) && $stable(alive_vec) && $stable(lock_vec) && !test_done));

endmodule

bind wlt_test_init wlt_chk #(.MC(MC)) u_wlt_chk (
  .clk(clk), .rst_n(rst_n), .start_req(start_req), .tick(tick), .phase(phase),
  .line_pull(line_pull), .test_done(test_done), .alive_vec(alive_vec), .lock_vec(lock_vec)
);

// File: tb/test_wlt_test_init.sv
module test_wlt_test_init;

  localparam int MC = 4, T_SYNC = 6, T_GAP = 3, T_MARK = 4, N_MARK = 3, T_PBIT = 4;
  localparam int T_PAUSE = 10, T_WAKE = 5, T_SLOT = 6;
  localparam int PRE   = T_SYNC + T_GAP + N_MARK * T_MARK + 5 * T_PBIT + T_PAUSE + T_WAKE;
  localparam int TOTAL = PRE + 2 * MC * T_SLOT;

  // row: code[22:18] own_alive[17] own_lock[16] resp_alive[15:12] resp_lock[11:8]
  //      expected alive[7:4] expected lock[3:0]
  localparam int NROW = 6;
  localparam logic [22:0] VEC [NROW] = '{
    {5'b00100, 1'b1, 1'b1, 4'b1010, 4'b0010, 4'b1011, 4'b0011},
    {5'b11111, 1'b0, 1'b0, 4'b0000, 4'b0000, 4'b0000, 4'b0000},
    {5'b00000, 1'b1, 1'b0, 4'b1110, 4'b1110, 4'b1111, 4'b1110},
    {5'b10101, 1'b0, 1'b1, 4'b0001, 4'b1000, 4'b0001, 4'b1001},
    {5'b01010, 1'b1, 1'b1, 4'b1111, 4'b1111, 4'b1111, 4'b1111},
    {5'b10011, 1'b0, 1'b0, 4'b1000, 4'b0100, 4'b1000, 4'b0100}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          arst_n = 1'b0;
  logic          start_req = 1'b0;
  logic [4:0]    test_code = '0;
  logic          own_alive = 1'b0, own_lock = 1'b0;
  logic          tick = 1'b0;
  logic          ext_pull = 1'b0;
  logic          line_in, line_pull, test_done;
  logic [MC-1:0] alive_vec, lock_vec;

  assign line_in = !(line_pull || ext_pull);

  wlt_test_init #(
    .MC(MC), .T_SYNC(T_SYNC), .T_GAP(T_GAP), .T_MARK(T_MARK), .N_MARK(N_MARK),
    .T_PBIT(T_PBIT), .T_PAUSE(T_PAUSE), .T_WAKE(T_WAKE), .T_SLOT(T_SLOT)
  ) i_wlt_test_init (
    .clk(clk), .arst_n(arst_n), .start_req(start_req), .test_code(test_code),
    .own_alive(own_alive), .own_lock(own_lock), .tick(tick), .line_in(line_in),
    .line_pull(line_pull), .test_done(test_done), .alive_vec(alive_vec), .lock_vec(lock_vec)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected pull after n ticks of a test
  function automatic logic exp_pull(input int n, input logic [4:0] c, input logic oa, input logic ol);
    int m = n;
    if (m < T_SYNC) return 1'b1;
    m -= T_SYNC;
    if (m < T_GAP) return 1'b0;
    m -= T_GAP;
    if (m < N_MARK * T_MARK) return ((m % T_MARK) < T_MARK / 2);
    m -= N_MARK * T_MARK;
    if (m < 5 * T_PBIT) return !c[4 - m / T_PBIT];
    m -= 5 * T_PBIT;
    if (m < T_PAUSE + T_WAKE) return 1'b0;
    m -= T_PAUSE + T_WAKE;
    if (m < 2 * MC * T_SLOT) begin
      if (m / T_SLOT == 0) return oa;
      if (m / T_SLOT == 1) return ol;
    end
    return 1'b0;
  endfunction

  function automatic int grp_of(input int n);
    if (n < T_SYNC + T_GAP) return 0;
    if (n < T_SYNC + T_GAP + N_MARK * T_MARK) return 1;
    if (n < PRE - T_PAUSE - T_WAKE) return 2;
    if (n < PRE) return 3;
    return 4;
  endfunction

  function automatic int res_slot(input int n);
    if (n < PRE || n >= TOTAL) return -1;
    return (n - PRE) / T_SLOT;
  endfunction

  task automatic run_test(input logic [4:0] c, input logic oa, input logic ol,
                          input logic [3:0] ra, input logic [3:0] rl,
                          input int div, input int ign_cyc, output int werr);
    int perr[5];
    int n, cyc, s, early;
    bit seen;
    foreach (perr[i]) perr[i] = 0;
    start_req = 1'b1; test_code = c; own_alive = oa; own_lock = ol; tick = 1'b0; ext_pull = 1'b0;
    @(posedge clk); #2;
    start_req = 1'b0; test_code = ~c; own_alive = ~oa; own_lock = ~ol;
    chk(alive_vec == '0 && lock_vec == '0, "R2", "vectors cleared at start",
        int'({alive_vec, lock_vec}), 0);
    n = 0; cyc = 0; seen = 1'b0; early = 0;
    while (!seen && cyc < TOTAL * div * 2 + 50) begin
      bit tk;
      tk = ((cyc % div) == div - 1);
      tick = tk;
      start_req = (cyc == ign_cyc);
      s = res_slot(n);
      ext_pull = (s < 0) ? 1'b0 : ((s % 2) ? rl[s / 2] : ra[s / 2]);
      @(posedge clk); #2;
      tick = 1'b0; start_req = 1'b0;
      if (tk) n++;
      cyc++;
      if (n < TOTAL) begin
        if (line_pull !== exp_pull(n, c, oa, ol)) perr[grp_of(n)]++;
        if (test_done) early++;
      end else begin
        seen = 1'b1;
        chk(test_done === 1'b1, "R9", "done after last slot tick", int'(test_done), 1);
      end
    end
    ext_pull = 1'b0;
    chk(seen && early == 0, "R9", "done timing (early pulses)", early, 0);
    chk(perr[0] == 0, "R2", "start sequence mismatches", perr[0], 0);
    chk(perr[1] == 0, "R3", "indicator mismatches", perr[1], 0);
    chk(perr[2] == 0, "R4", "parameter bit mismatches", perr[2], 0);
    chk(perr[3] == 0, "R5", "pause/startup mismatches", perr[3], 0);
    chk(perr[4] == 0, "R6 R7", "result slot drive mismatches", perr[4], 0);
    werr = perr[0] + perr[1] + perr[2] + perr[3] + perr[4] + early;
    tick = 1'b1;
    @(posedge clk); #2;
    tick = 1'b0;
    chk(!test_done && !line_pull, "R9", "done lasts one clock, line released",
        int'({test_done, line_pull}), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int werr;
    logic [3:0] ea, el;
    repeat (3) @(posedge clk);
    #2 arst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    chk(!line_pull && !test_done && alive_vec == '0 && lock_vec == '0, "R1", "reset state",
        int'({line_pull, test_done, alive_vec, lock_vec}), 0);
    // R11: ticks with no start leave the idle block untouched
    tick = 1'b1;
    repeat (5) @(posedge clk);
    #2 tick = 1'b0;
    chk(!line_pull && !test_done, "R11", "idle ticks do nothing", int'({line_pull, test_done}), 0);

    // table walk, one tick per clock
    for (int r = 0; r < NROW; r++) begin
      run_test(VEC[r][22:18], VEC[r][17], VEC[r][16], VEC[r][15:12], VEC[r][11:8], 1, -1, werr);
      ea = VEC[r][7:4]; el = VEC[r][3:0];
      chk(alive_vec == ea, "R8", $sformatf("row %0d alive vector", r), alive_vec, ea);
      chk(lock_vec == el, "R8", $sformatf("row %0d lock vector", r), lock_vec, el);
    end

    // R9: vectors hold while idle
    tick = 1'b1;
    repeat (6) @(posedge clk);
    #2 tick = 1'b0;
    chk(alive_vec == 4'b1000 && lock_vec == 4'b0100 && !line_pull, "R9", "vectors hold after done",
        int'({alive_vec, lock_vec}), int'(8'b1000_0100));

    // R11: slow timebase, one tick every third clock
    run_test(5'b00100, 1'b1, 1'b1, 4'b1010, 4'b0010, 3, -1, werr);
    chk(werr == 0, "R11", "gated timebase waveform errors", werr, 0);
    chk(alive_vec == 4'b1011 && lock_vec == 4'b0011, "R11", "gated timebase vectors",
        int'({alive_vec, lock_vec}), int'(8'b1011_0011));

    // R10: start request with another code in the middle of the parameter bits
    run_test(5'b10101, 1'b0, 1'b1, 4'b0001, 4'b1000, 1, 25, werr);
    chk(werr == 0, "R10", "busy start changed waveform", werr, 0);
    chk(alive_vec == 4'b0001 && lock_vec == 4'b1001, "R10", "busy start vectors",
        int'({alive_vec, lock_vec}), int'(8'b0001_1001));

    // R1: asynchronous reset during a result sequence
    start_req = 1'b1; test_code = 5'b00000; own_alive = 1'b1; own_lock = 1'b1; tick = 1'b0;
    @(posedge clk); #2 start_req = 1'b0; tick = 1'b1;
    repeat (PRE + 3) @(posedge clk);
    #2 tick = 1'b0;
    chk(line_pull === 1'b1, "R7", "own alive drive in class-1 slot", int'(line_pull), 1);
    arst_n = 1'b0;
    #2;
    chk(!line_pull && alive_vec == '0 && lock_vec == '0, "R1", "async reset mid-test",
        int'({line_pull, alive_vec, lock_vec}), 0);
    @(posedge clk); #2 arst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    run_test(VEC[0][22:18], VEC[0][17], VEC[0][16], VEC[0][15:12], VEC[0][11:8], 1, -1, werr);
    chk(alive_vec == 4'b1011 && lock_vec == 4'b0011, "R8", "test after reset",
        int'({alive_vec, lock_vec}), int'(8'b1011_0011));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule